// File: doc/BRIEF.md
# Timer Event Flag Register

This block holds the sticky event flags of a 16-bit timer/counter. It compares the running counter against three compare values, A, B and C. The flag of a channel comes up one timer tick after the counter equals that channel's value. It also latches an overflow event and an input-capture event. The overflow event is chosen according to the waveform mode.

Each flag stays set until one of two things clears it. The interrupt vector tied to the flag can be acknowledged with a one-cycle pulse, or software can write a one to the flag's bit. Each flag is ANDed with its bit of an interrupt mask to form an interrupt request line.

The register reads back as an 8-bit value. The counter, the waveform logic, the capture data and the interrupt controller live outside this block.

Top module: `tflag_reg`

## Requirements
- R1: While the synchronous active-low reset is applied, every flag is cleared, and after reset the register reads 0x00 and all request lines are low.
- R2: The compare flags sit at bit 1 (A), bit 2 (B) and bit 3 (C). A compare flag rises one timer tick after the tick on which the counter equalled that channel's compare value, and never on the matching tick itself.
- R3: The counter is compared only on cycles where `tick` is high, and the delayed set also takes effect only on a later cycle where `tick` is high. A match present only while `tick` is low sets nothing.
- R4: A force-compare strobe never sets a compare flag.
- R5: Writing a one to a flag's bit with `wr_en` clears that flag. Writing a zero leaves it unchanged.
- R6: An acknowledge pulse on a vector clears only the flag of that vector.
- R7: When a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R8: The overflow flag sits at bit 0. With `mode_plain` high it is set by `wrap_evt`, and with `mode_plain` low it is set by `turn_evt`. The event that the mode does not select is ignored, and both events count only on a `tick` cycle.
- R9: The capture flag sits at bit 5 and is set by `cap_evt` on any cycle, whatever the state of `tick`.
- R10: Bits 4, 6 and 7 always read zero, and writes to them have no effect.
- R11: Each request line is high exactly when its flag is set and the `irq_mask` bit at the same position is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled timer clock enable |
| cnt | input | 16 | Current counter value |
| cmp_vals | input | 48 | Compare values, A in bits 15:0, B in 31:16, C in 47:32 |
| force_cmp | input | 3 | Force-compare strobes, A in bit 0 |
| cap_evt | input | 1 | Input-capture event pulse |
| mode_plain | input | 1 | High for free-running or clear-on-match modes |
| wrap_evt | input | 1 | Counter overflow event |
| turn_evt | input | 1 | Top/bottom event of the other waveform modes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data, a one clears the flag at that bit |
| ack_ovf | input | 1 | Overflow vector acknowledge |
| ack_cmp | input | 3 | Compare vector acknowledges, A in bit 0 |
| ack_cap | input | 1 | Capture vector acknowledge |
| irq_mask | input | 8 | Interrupt enables, laid out like the flags |
| flags | output | 8 | Flag register read value |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 3 | Compare interrupt requests, A in bit 0 |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and three compare channels. This makes the full-scale compare value 0xFFFF reachable, along with several channels matching on the same tick. With `tick` driven by hand, the bench can stretch the gap between the matching tick and the setting tick. It can also collide sets with both kinds of clear on each flag position.

// File: rtl/tflag_pkg.sv
// Shared constants and helpers for the timer event flag register.
// Assumes at most three compare channels, so that they fit below the capture bit.
package tflag_pkg;

    localparam int REG_W    = 8;
    localparam int OVF_BIT  = 0;
    localparam int CMP_BASE = 1;
    localparam int CAP_BIT  = 5;

    // Mask of the implemented flag positions for a given channel count.
    function automatic logic [REG_W-1:0] impl_mask(input int n_cmp);
        logic [REG_W-1:0] m;
        m = '0;
        m[OVF_BIT] = 1'b1;
        for (int k = 0; k < n_cmp; k++) begin
            m[CMP_BASE + k] = 1'b1;
        end
        m[CAP_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/tflag_cell.sv
// One sticky flag bit.
// A set request takes priority over a clear request in the same cycle.
// Assumes set_i and clr_i are single-cycle qualified requests.
module tflag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Sticky flag storage with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);                                  // R7
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);                     // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));            // R6

endmodule

// File: rtl/tflag_cmp_chan.sv
// One compare channel.
// On a tick it records whether the counter equals the compare value.
// A recorded match produces a set pulse on the following tick.
// The force strobe is observed only by the check below and never produces a set.
module tflag_cmp_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             force_i,
    output logic             set_o
);

    logic hit;
    logic pend_q;

    // Compare the counter against this channel's value.
    always_comb hit = (cnt_i == cmp_i);

    // Record the compare result on every tick, so it is held between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (tick_i) pend_q <= hit;
    end

    // Release the recorded match on the next tick.
    always_comb set_o = pend_q & tick_i;

    AST_FORCE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && tick_i && !hit) |=> !set_o);         // R4
    AST_NO_SET_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !hit) |=> !set_o);                    // R2

endmodule

// File: rtl/tflag_ovf_src.sv
// Chooses the overflow set event according to the waveform mode.
// Assumes wrap_i and turn_i are aligned to timer ticks.
module tflag_ovf_src (
    input  logic tick_i,
    input  logic mode_plain_i,
    input  logic wrap_i,
    input  logic turn_i,
    output logic set_o
);

    // Pick the event of the active mode and qualify it with the tick.
    always_comb set_o = tick_i & (mode_plain_i ? wrap_i : turn_i);

endmodule

// File: rtl/tflag_reg.sv
// Timer event flag register.
// Collects the overflow, compare and capture events into sticky flags.
// Applies the write-one and acknowledge clears, and gates the requests with the mask.
// Assumes NUM_CMP <= 3 so that the compare flags fit at bits 1..3.
module tflag_reg
    import tflag_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [CNT_W-1:0]         cnt,
    input  logic [NUM_CMP*CNT_W-1:0] cmp_vals,
    input  logic [NUM_CMP-1:0]       force_cmp,
    input  logic                     cap_evt,
    input  logic                     mode_plain,
    input  logic                     wrap_evt,
    input  logic                     turn_evt,
    input  logic                     wr_en,
    input  logic [REG_W-1:0]         wr_data,
    input  logic                     ack_ovf,
    input  logic [NUM_CMP-1:0]       ack_cmp,
    input  logic                     ack_cap,
    input  logic [REG_W-1:0]         irq_mask,
    output logic [REG_W-1:0]         flags,
    output logic                     irq_ovf,
    output logic [NUM_CMP-1:0]       irq_cmp,
    output logic                     irq_cap
);

    localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_CMP);

    logic [NUM_CMP-1:0] cmp_set;
    logic               ovf_set;
    logic [REG_W-1:0]   set_vec;
    logic [REG_W-1:0]   ack_vec;
    logic [REG_W-1:0]   clr_vec;
    logic [REG_W-1:0]   flag_q;
    logic               unused_bits;

    // One compare channel per compare value.
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        tflag_cmp_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .cnt_i   (cnt),
            .cmp_i   (cmp_vals[k*CNT_W +: CNT_W]),
            .force_i (force_cmp[k]),
            .set_o   (cmp_set[k])
        );
    end

    tflag_ovf_src u_ovf (
        .tick_i       (tick),
        .mode_plain_i (mode_plain),
        .wrap_i       (wrap_evt),
        .turn_i       (turn_evt),
        .set_o        (ovf_set)
    );

    // Place each set event and acknowledge at its flag position.
    always_comb begin
        set_vec = '0;
        ack_vec = '0;
        set_vec[OVF_BIT] = ovf_set;
        ack_vec[OVF_BIT] = ack_ovf;
        for (int k = 0; k < NUM_CMP; k++) begin
            set_vec[CMP_BASE + k] = cmp_set[k];
            ack_vec[CMP_BASE + k] = ack_cmp[k];
        end
        set_vec[CAP_BIT] = cap_evt;
        ack_vec[CAP_BIT] = ack_cap;
    end

    // Merge the write-one clear with the vector acknowledges.
    always_comb clr_vec = ack_vec | ({REG_W{wr_en}} & wr_data);

    // A flag cell where a flag exists, a constant zero elsewhere.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_flag
            tflag_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q_o   (flag_q[i])
            );
        end else begin : g_zero
            assign flag_q[i] = 1'b0;
        end
    end

    // Read value and masked interrupt requests.
    always_comb begin
        flags   = flag_q;
        irq_ovf = flag_q[OVF_BIT] & irq_mask[OVF_BIT];
        irq_cap = flag_q[CAP_BIT] & irq_mask[CAP_BIT];
        for (int k = 0; k < NUM_CMP; k++) begin
            irq_cmp[k] = flag_q[CMP_BASE + k] & irq_mask[CMP_BASE + k];
        end
    end

    // Mask, write and set bits at unused positions are intentionally dropped.
    assign unused_bits = ^{wr_data & ~IMPL, irq_mask & ~IMPL, set_vec & ~IMPL, clr_vec & ~IMPL};

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_chk
        AST_CMP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[CMP_BASE + k]) |-> $past(tick));             // R3
    end
    AST_CAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flags[CAP_BIT]);                                 // R9
    AST_OVF_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_plain && wrap_evt) |=> flags[OVF_BIT]);        // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~IMPL) == '0);                                      // R10

endmodule

// File: tb/test_tflag_reg.sv
module test_tflag_reg;

    localparam int PERIOD = 10;
    localparam int CW = 16;
    localparam int NC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic [CW-1:0] cv [NC];
    logic [NC*CW-1:0] cmp_vals;
    logic [NC-1:0] force_cmp = '0;
    logic cap_evt = 1'b0, mode_plain = 1'b1, wrap_evt = 1'b0, turn_evt = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic ack_ovf = 1'b0, ack_cap = 1'b0;
    logic [NC-1:0] ack_cmp = '0;
    logic [7:0] irq_mask = '0;
    logic [7:0] flags;
    logic irq_ovf, irq_cap;
    logic [NC-1:0] irq_cmp;

    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;
    always_comb cmp_vals = {cv[2], cv[1], cv[0]};

    tflag_reg #(.CNT_W(CW), .NUM_CMP(NC)) i_tflag_reg (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cmp_vals(cmp_vals),
        .force_cmp(force_cmp), .cap_evt(cap_evt), .mode_plain(mode_plain),
        .wrap_evt(wrap_evt), .turn_evt(turn_evt), .wr_en(wr_en), .wr_data(wr_data),
        .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .ack_cap(ack_cap), .irq_mask(irq_mask),
        .flags(flags), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .irq_cap(irq_cap)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        wr_en = 1'b1; wr_data = 8'hFF; cyc();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic t_reset();
        chk("R1 flags after reset", flags, 8'h00);
        chk("R1 requests after reset", {irq_ovf, irq_cmp, irq_cap}, 0);
    endtask

    task automatic t_cmp_basic();
        for (int k = 0; k < NC; k++) begin
            tick = 1'b1; cnt = cv[k]; cyc();
            chk("R2 no flag on matching tick", flags, 8'h00);
            cnt = 16'h0001; cyc();
            chk("R2 flag one tick after match", flags, 8'(1 << (1 + k)));
            clear_all();
        end
    endtask

    task automatic t_tick_gate();
        tick = 1'b0; cnt = cv[0]; cyc(); cyc();
        cnt = 16'h0001; tick = 1'b1; cyc();
        chk("R3 match without tick ignored", flags, 8'h00);
        cnt = cv[0]; cyc();
        cnt = 16'h0001; tick = 1'b0; cyc(); cyc(); cyc();
        chk("R3 set waits for next tick", flags, 8'h00);
        tick = 1'b1; cyc();
        chk("R3 set on later tick", flags, 8'h02);
        clear_all();
    endtask

    task automatic t_force();
        tick = 1'b1; cnt = 16'h0001; force_cmp = '1; cyc(); cyc(); cyc();
        force_cmp = '0; cyc();
        chk("R4 force strobe sets nothing", flags, 8'h00);
    endtask

    task automatic t_write();
        cap_evt = 1'b1; cyc(); cap_evt = 1'b0;
        wr_en = 1'b1; wr_data = 8'h00; cyc();
        chk("R5 write zero keeps flag", flags, 8'h20);
        wr_data = 8'h0F; cyc();
        chk("R5 write one elsewhere keeps flag", flags, 8'h20);
        wr_data = 8'h20; cyc();
        wr_en = 1'b0; wr_data = 8'h00;
        chk("R5 write one clears", flags, 8'h00);
    endtask

    task automatic t_ack();
        tick = 1'b1; cnt = cv[1]; cyc(); cnt = 16'h0001; cyc();
        ack_cmp = 3'b101; ack_ovf = 1'b1; ack_cap = 1'b1; cyc();
        chk("R6 other acks leave flag", flags, 8'h04);
        ack_cmp = 3'b010; ack_ovf = 1'b0; ack_cap = 1'b0; cyc();
        ack_cmp = '0;
        chk("R6 own ack clears", flags, 8'h00);
    endtask

    task automatic t_collide();
        cap_evt = 1'b1; cyc();
        wr_en = 1'b1; wr_data = 8'h20; cyc();
        wr_en = 1'b0; wr_data = 8'h00;
        chk("R7 set beats write clear", flags, 8'h20);
        ack_cap = 1'b1; cyc();
        cap_evt = 1'b0; ack_cap = 1'b0;
        chk("R7 set beats ack", flags, 8'h20);
        tick = 1'b1; mode_plain = 1'b1; wrap_evt = 1'b1; ack_ovf = 1'b1; cyc();
        wrap_evt = 1'b0; ack_ovf = 1'b0;
        chk("R7 overflow set beats ack", flags, 8'h21);
        clear_all();
    endtask

    task automatic t_ovf();
        tick = 1'b1; mode_plain = 1'b1; turn_evt = 1'b1; cyc(); turn_evt = 1'b0;
        chk("R8 plain mode ignores turn", flags, 8'h00);
        tick = 1'b0; wrap_evt = 1'b1; cyc();
        chk("R8 wrap without tick ignored", flags, 8'h00);
        tick = 1'b1; cyc(); wrap_evt = 1'b0;
        chk("R8 plain mode wrap sets", flags, 8'h01);
        clear_all();
        mode_plain = 1'b0; wrap_evt = 1'b1; cyc(); wrap_evt = 1'b0;
        chk("R8 other mode ignores wrap", flags, 8'h00);
        turn_evt = 1'b1; cyc(); turn_evt = 1'b0;
        chk("R8 other mode turn sets", flags, 8'h01);
        clear_all();
        mode_plain = 1'b1;
    endtask

    task automatic t_cap();
        tick = 1'b0; cap_evt = 1'b1; cyc(); cap_evt = 1'b0;
        chk("R9 capture sets without tick", flags, 8'h20);
        clear_all();
    endtask

    task automatic t_rsvd();
        wr_en = 1'b1; wr_data = 8'hD0; cyc(); wr_en = 1'b0; wr_data = 8'h00;
        chk("R10 reserved bits stay zero", flags & 8'hD0, 8'h00);
    endtask

    task automatic set_all();
        cv[0] = 16'h0042; cv[1] = 16'h0042; cv[2] = 16'h0042;
        tick = 1'b1; cnt = 16'h0042; cap_evt = 1'b1; wrap_evt = 1'b1; cyc();
        cap_evt = 1'b0; wrap_evt = 1'b0; cnt = 16'h0001; cyc();
    endtask

    task automatic t_irq();
        set_all();
        chk("R2 all channels on one tick", flags, 8'h2F);
        chk("R10 reserved zero with all set", flags & 8'hD0, 8'h00);
        irq_mask = 8'h00; #1;
        chk("R11 mask off", {irq_ovf, irq_cmp, irq_cap}, 0);
        irq_mask = 8'hFF; #1;
        chk("R11 mask all", {irq_ovf, irq_cmp, irq_cap}, 5'b11111);
        irq_mask = 8'h25; #1;
        chk("R11 partial mask", {irq_ovf, irq_cmp, irq_cap}, 5'b1_010_1);
        wr_en = 1'b1; wr_data = 8'h01; cyc(); wr_en = 1'b0; wr_data = 8'h00;
        chk("R11 request drops with flag", {irq_ovf, irq_cmp, irq_cap}, 5'b0_010_1);
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        chk("R1 reset clears set flags", flags, 8'h00);
        irq_mask = 8'h00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cv[0] = 16'h1234; cv[1] = 16'h00FF; cv[2] = 16'hFFFF;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_cmp_basic();
        t_tick_gate();
        t_force();
        t_write();
        t_ack();
        t_collide();
        t_ovf();
        t_cap();
        t_rsvd();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule